// File: doc/BRIEF.md
# Extended Control Register Write Checker

This block guards the privileged write path of a 64-bit extended control register whose low bits switch processor state components on and off. A write request supplies a 32-bit register index and two 32-bit data words, the high word and the low word. Alongside it the block receives status: the current privilege level, the operating mode, a flag saying the feature exists, a flag saying the operating system has enabled it, and decoded prefix flags for lock, operand size and the two repeat forms.

For each request the block makes one decision in one cycle. It either commits the 64-bit value to the register or reports exactly one fault. The fault is either an invalid-opcode fault or a general-protection fault. Invalid-opcode causes take priority over every general-protection cause. The register contents are always visible on a read port. A fault leaves the register untouched. Decoding the instruction, delivering the fault and saving the enabled state all belong to other blocks.

Top module: `xcr_write_checker`

## Requirements
- R1: After reset the register reads 64'h1, and neither the commit pulse nor the fault pulse is high.
- R2: A request with no fault cause loads {high word, low word} into the register, with the high word in bits 63:32. In the next cycle the register shows the new value and `wr_done` is high for that one cycle.
- R3: An invalid-opcode fault (code 2'b01) is raised when any of these holds: `feat_ok` is 0, `os_en` is 0, or any of `pfx_lock`, `pfx_opsize`, `pfx_repe`, `pfx_repne` is 1. This fault wins over every general-protection cause.
- R4: In virtual-8086 mode (`mode` = 2'b10), every request without an invalid-opcode cause raises a general-protection fault (code 2'b10), whatever the privilege level.
- R5: In protected mode (2'b01) and in 64-bit/compatibility mode (2'b11), a request with `cpl` other than 0 raises a general-protection fault. In real mode (2'b00), `cpl` has no effect.
- R6: Any nonzero value in any bit of the 32-bit index raises a general-protection fault. Only index 0 exists.
- R7: Setting any bit outside the implemented mask (default bits 2:0) raises a general-protection fault. This covers bits in the high word.
- R8: A value with bit 0 clear raises a general-protection fault.
- R9: A value with bits 2:1 equal to 2'b10 raises a general-protection fault. The values 2'b00, 2'b01 and 2'b11 are allowed.
- R10: On a fault the register keeps its previous value, and `flt_valid` is high for one cycle with the code. Each request produces exactly one of `wr_done` and `flt_valid`. A cycle with no request produces neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request present this cycle |
| wr_index | input | 32 | Register index |
| wr_hi | input | 32 | High data word, bits 63:32 |
| wr_lo | input | 32 | Low data word, bits 31:0 |
| cpl | input | 2 | Current privilege level |
| mode | input | 2 | 00 real, 01 protected, 10 virtual-8086, 11 64-bit/compatibility |
| feat_ok | input | 1 | Feature supported |
| os_en | input | 1 | Feature enabled by the operating system |
| pfx_lock | input | 1 | Lock prefix present |
| pfx_opsize | input | 1 | Operand-size prefix present |
| pfx_repe | input | 1 | Repeat-equal prefix present |
| pfx_repne | input | 1 | Repeat-not-equal prefix present |
| xcr_q | output | 64 | Register contents |
| wr_done | output | 1 | One-cycle commit pulse |
| flt_valid | output | 1 | One-cycle fault pulse |
| flt_code | output | 2 | 01 invalid opcode, 10 general protection, 00 otherwise |

## Verification
Every result is due exactly one clock after the edge that samples the request: the commit or fault pulse, the fault code, and the updated or held register value. Each queued expectation therefore carries the cycle number in which it falls due. The monitor samples at the falling edge and compares only in that cycle. Any pulse seen in a cycle with nothing due counts as a failure. Idle expectations confirm that a fault left the register unchanged and that a cycle without a request stays silent.

// File: rtl/xcr_write_checker.sv
module xcr_write_checker #(
  parameter logic [63:0] IMPL_MASK = 64'h7,
  parameter logic [63:0] RESET_VAL = 64'h1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [31:0] wr_index,
  input  logic [31:0] wr_hi,
  input  logic [31:0] wr_lo,
  input  logic [1:0]  cpl,
  input  logic [1:0]  mode,
  input  logic        feat_ok,
  input  logic        os_en,
  input  logic        pfx_lock,
  input  logic        pfx_opsize,
  input  logic        pfx_repe,
  input  logic        pfx_repne,
  output logic [63:0] xcr_q,
  output logic        wr_done,
  output logic        flt_valid,
  output logic [1:0]  flt_code
);

  localparam logic [1:0] MODE_REAL = 2'b00;
  localparam logic [1:0] MODE_V86  = 2'b10;
  localparam logic [1:0] CODE_UD   = 2'b01;
  localparam logic [1:0] CODE_GP   = 2'b10;
  localparam logic [63:0] RSVD_MASK = ~IMPL_MASK;

  logic [63:0] wval;
  logic ud, gp_mode, gp_data, gp, ok;

  assign wval    = {wr_hi, wr_lo};
  assign ud      = !feat_ok || !os_en || pfx_lock || pfx_opsize || pfx_repe || pfx_repne;
  assign gp_mode = (mode == MODE_V86) || ((mode != MODE_REAL) && (cpl != 2'd0));
  assign gp_data = (wr_index != 32'd0) || ((wval & RSVD_MASK) != 64'd0) ||
                   !wval[0] || (wval[2:1] == 2'b10);
  assign gp      = gp_mode || gp_data;
  assign ok      = wr_valid && !ud && !gp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xcr_q     <= RESET_VAL;
      wr_done   <= 1'b0;
      flt_valid <= 1'b0;
      flt_code  <= 2'b00;
    end else begin
      wr_done   <= ok;
      flt_valid <= wr_valid && (ud || gp);
      flt_code  <= !wr_valid ? 2'b00 : ud ? CODE_UD : gp ? CODE_GP : 2'b00;
      if (ok) xcr_q <= wval;
    end
  end

  a_r1_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_done && flt_valid));
  a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !wr_done && !flt_valid);
  a_r10_hold_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> xcr_q == $past(xcr_q));
  a_r2_commit_value: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> xcr_q == {$past(wr_hi), $past(wr_lo)});
  a_r3_ud_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && (!feat_ok || pfx_lock) |=> flt_valid && flt_code == CODE_UD);
  a_r4_v86_faults: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && mode == MODE_V86 |=> flt_valid);
  a_r8_bit0_kept: assert property (@(posedge clk) disable iff (!rst_n)
    xcr_q[0]);
  a_r9_pair_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !(xcr_q[2] && !xcr_q[1]));
  a_r7_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (xcr_q & RSVD_MASK) == 64'd0);

endmodule

// File: tb/tb_xcr_write_checker.sv
`timescale 1ns/1ps
module tb_xcr_write_checker;
  logic clk = 0, rst_n = 0, wr_valid = 0;
  logic [31:0] wr_index = 0, wr_hi = 0, wr_lo = 0;
  logic [1:0] cpl = 0, mode = 0;
  logic feat_ok = 0, os_en = 0, pfx_lock = 0, pfx_opsize = 0, pfx_repe = 0, pfx_repne = 0;
  logic [63:0] xcr_q;
  logic wr_done, flt_valid;
  logic [1:0] flt_code;

  always #4 clk = ~clk;

  xcr_write_checker dut (.*);

  typedef struct {
    logic [31:0] idx, hi, lo;
    logic [1:0]  cpl, mode;
    logic feat, os, lk, op, re, rn;
  } req_t;

  typedef struct {
    logic done, flt;
    logic [1:0] code;
    logic [63:0] x;
    int due;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, total = 0, fails = 0;
  logic [63:0] exp_x = 64'h1;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [1:0] model(req_t r);
    logic [63:0] v;
    v = {r.hi, r.lo};
    if (!r.feat || !r.os || r.lk || r.op || r.re || r.rn) return 2'b01;
    if (r.mode == 2'b10) return 2'b10;
    if (r.mode != 2'b00 && r.cpl != 0) return 2'b10;
    if (r.idx != 0 || (v & ~64'h7) != 0 || !v[0] || v[2:1] == 2'b10) return 2'b10;
    return 2'b00;
  endfunction

  function automatic req_t good();
    req_t r;
    r.idx = 0; r.hi = 0; r.lo = 32'h7; r.cpl = 0; r.mode = 2'b01;
    r.feat = 1; r.os = 1; r.lk = 0; r.op = 0; r.re = 0; r.rn = 0;
    return r;
  endfunction

  task automatic send(req_t r, string tag);
    exp_t e;
    logic [1:0] c;
    @(negedge clk);
    wr_valid = 1; wr_index = r.idx; wr_hi = r.hi; wr_lo = r.lo; cpl = r.cpl; mode = r.mode;
    feat_ok = r.feat; os_en = r.os; pfx_lock = r.lk; pfx_opsize = r.op;
    pfx_repe = r.re; pfx_repne = r.rn;
    c = model(r);
    if (c == 2'b00) exp_x = {r.hi, r.lo};
    e.done = (c == 2'b00); e.flt = (c != 2'b00); e.code = c; e.x = exp_x;
    e.due = cyc + 1; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    exp_t e;
    @(negedge clk);
    wr_valid = 0;
    e.done = 0; e.flt = 0; e.code = 0; e.x = exp_x; e.due = cyc + 1; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (wr_done !== e.done || flt_valid !== e.flt || flt_code !== e.code || xcr_q !== e.x) begin
          fails++;
          $display("FAIL %s: done=%b flt=%b code=%b x=%h expected done=%b flt=%b code=%b x=%h",
                   e.tag, wr_done, flt_valid, flt_code, xcr_q, e.done, e.flt, e.code, e.x);
        end
      end else if (wr_done || flt_valid) begin
        total++; fails++;
        $display("FAIL R10 unexpected pulse: done=%b flt=%b expected 0 0", wr_done, flt_valid);
      end
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    req_t r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    total++;
    if (xcr_q !== 64'h1 || wr_done !== 0 || flt_valid !== 0) begin
      fails++;
      $display("FAIL R1 reset: x=%h done=%b flt=%b expected x=1 done=0 flt=0", xcr_q, wr_done, flt_valid);
    end
    r = good(); send(r, "R2 commit 7 protected");
    idle("R10 idle after commit");
    r = good(); r.mode = 2'b11; r.lo = 32'h3; send(r, "R2 commit 3 64-bit");
    r = good(); r.mode = 2'b00; r.cpl = 3; r.lo = 32'h1; send(r, "R5 real mode ignores cpl");
    r = good(); r.feat = 0; send(r, "R3 feature absent");
    r = good(); r.os = 0; send(r, "R3 os disabled");
    r = good(); r.lk = 1; send(r, "R3 lock");
    r = good(); r.op = 1; send(r, "R3 opsize");
    r = good(); r.re = 1; send(r, "R3 repe");
    r = good(); r.rn = 1; send(r, "R3 repne");
    r = good(); r.rn = 1; r.mode = 2'b10; r.idx = 5; r.lo = 0; send(r, "R3 priority over GP");
    idle("R10 hold after UD");
    r = good(); r.mode = 2'b10; send(r, "R4 v86 cpl0");
    r = good(); r.mode = 2'b10; r.cpl = 3; send(r, "R4 v86 cpl3");
    r = good(); r.cpl = 3; send(r, "R5 protected cpl3");
    r = good(); r.mode = 2'b11; r.cpl = 1; send(r, "R5 64-bit cpl1");
    r = good(); r.idx = 1; send(r, "R6 index 1");
    r = good(); r.idx = 32'h8000_0000; send(r, "R6 index msb");
    r = good(); r.lo = 32'hF; send(r, "R7 reserved bit 3");
    r = good(); r.hi = 32'h1; send(r, "R7 reserved bit 32");
    r = good(); r.lo = 32'h6; send(r, "R8 bit0 clear");
    r = good(); r.lo = 32'h0; r.mode = 2'b00; send(r, "R8 zero real mode");
    idle("R10 hold after GP");
    r = good(); r.lo = 32'h5; send(r, "R9 pair 10");
    r = good(); r.lo = 32'h1; send(r, "R9 pair 00 allowed");
    r = good(); r.lo = 32'h3; send(r, "R9 pair 01 allowed");
    r = good(); r.lo = 32'h7; send(r, "R9 pair 11 allowed");
    idle("R10 idle silent");
    idle("R10 idle silent 2");
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule